// File: doc/BRIEF.md
# System and Control Instruction Sequencer

This block executes the fixed-encoding system instructions of a 13-bit instruction set for an 8-bit core. It watches the instruction word offered on each cycle. When the word is one of the system forms, it carries out the operation. The operations are:

- decimal adjust of the accumulator;
- moves between the accumulator and a control register;
- writes and reads of the I/O control registers;
- global interrupt enable and disable;
- returns through an internal 8-entry hardware return stack;
- the sleep and watchdog-clear commands.

Words that are not system forms leave every output untouched, so the block can sit beside the data-path decoder.

Results destined for the accumulator, the carry flag and the program counter leave as one-cycle write strobes with data, on the cycle after the instruction is accepted. I/O control register accesses are strobed in the same cycle as the instruction. Return addresses enter through a push port driven by the call and interrupt logic. A sleep command halts the sequencer and holds the oscillator-stop output high until the wake input arrives.

Top module: `sys_seq`

## Requirements
- R1: After reset: `gie`=0, `t_flag`=1, `p_flag`=1, `cont_value`=0, `osc_stop`=0, and all strobes (`acc_we`, `c_we`, `pc_load`, `wdt_clr`, `ioc_we`, `ioc_re`) low.
- R2: Accepted words 0x0000, 0x0010–0x0014 and every word of 0x0020 or above change no output, no flag and no register.
- R3: Word 0x0001 is decimal adjust, with a result one cycle later on `acc_wdata`/`c_wdata` with `acc_we`=`c_we`=1. It proceeds in three steps:
  - The sum is A+6 when A's low nibble exceeds 9 or `dc_in`=1, otherwise A.
  - 0x60 more is added when that sum has a carry out of bit 7, or its high nibble exceeds 9, or `c_in`=1.
  - Carry out is 1 exactly when the 0x60 step was taken.
- R4: Word 0x0002 loads `cont_value` from `acc_rdata`. Word 0x000E returns `cont_value` on `acc_wdata` with `acc_we`=1 one cycle later. Neither raises `c_we`.
- R5: Words 0x0005–0x0009 and 0x000F raise `ioc_we` in the same cycle, with `ioc_addr` = low nibble of the word and `ioc_wdata` = `acc_rdata`.
- R6: Words 0x0015–0x001F raise `ioc_re` in the same cycle with `ioc_addr` = low nibble. One cycle later `acc_we`=1 and `acc_wdata` carries the `ioc_rdata` value that was sampled. Words 0x0010–0x0014 raise no strobe.
- R7: Word 0x000A sets `gie` and word 0x000B clears it, visible the next cycle.
- R8: Word 0x000C pops the return stack. One cycle later `pc_load`=1 and `pc_target` is the most recently pushed address not yet popped.
- R9: Word 0x000D behaves as 0x000C and also sets `gie` in the same step.
- R10: The stack holds 8 entries with a wrapping pointer. A ninth push overwrites the oldest entry, and returns then deliver pushed addresses in reverse order, wrapping around the pointer.
- R11: Word 0x0003 sets:
  - `wdt_clr` for one cycle;
  - `t_flag`=1 and `p_flag`=0;
  - `osc_stop`=1.

  While `osc_stop`=1 every offered word is ignored. `wake`=1 clears `osc_stop` on the next edge.
- R12: Word 0x0004 sets `wdt_clr` for one cycle and sets `t_flag`=1 and `p_flag`=1, without entering sleep.
- R13: A push and a return in the same cycle return the previous top, and the pushed address takes its place on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is offered this cycle |
| instr | input | 13 | Instruction word |
| acc_rdata | input | 8 | Current accumulator value |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current digit-carry flag |
| ioc_rdata | input | 8 | Read data of the addressed I/O control register |
| push_en | input | 1 | Push a return address |
| push_addr | input | PC_W | Return address to push |
| wake | input | 1 | Wake request ending sleep |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | Accumulator write data |
| c_we | output | 1 | Carry flag write strobe |
| c_wdata | output | 1 | Carry flag write value |
| ioc_we | output | 1 | I/O control register write strobe |
| ioc_re | output | 1 | I/O control register read strobe |
| ioc_addr | output | 4 | I/O control register index |
| ioc_wdata | output | 8 | I/O control register write data |
| pc_load | output | 1 | Program counter load strobe |
| pc_target | output | PC_W | Address to load into the program counter |
| cont_value | output | 8 | Control register contents |
| gie | output | 1 | Global interrupt enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| osc_stop | output | 1 | Oscillator stopped (sleep state) |
| t_flag | output | 1 | Time-out status bit |
| p_flag | output | 1 | Power-down status bit |

## Verification
Some rules are checked by the in-RTL properties on every cycle:
- at most one I/O control strobe is active, and only for a legal index;
- a program counter load follows a return exactly;
- an enable or disable shows on `gie` on the next cycle;
- sleep holds until wake, and no word is accepted while asleep;
- the stack pointer steps down by one on a plain return.

Other behaviour only the directed scenarios can show:
- the decimal-adjust arithmetic;
- the contents returned by the stack after wrap and after a push coinciding with a return;
- the control register round trip;
- the absence of effects for reserved and non-system words.

// File: rtl/sys_seq_pkg.sv
package sys_seq_pkg;

  localparam int INSTR_W = 13;
  localparam int DATA_W  = 8;
  localparam int IOC_W   = 4;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_DAA,
    OP_CONTW,
    OP_SLEEP,
    OP_WDTC,
    OP_IOW,
    OP_ENI,
    OP_DISI,
    OP_RET,
    OP_RETI,
    OP_CONTR,
    OP_IOR
  } sys_op_e;

  // Classify a word; anything outside the system page maps to OP_NONE.
  function automatic sys_op_e sys_classify(input logic [INSTR_W-1:0] w);
    sys_op_e op;
    op = OP_NONE;
    if (w[INSTR_W-1:5] == '0) begin
      if (!w[4]) begin
        case (w[3:0])
          4'h1:    op = OP_DAA;
          4'h2:    op = OP_CONTW;
          4'h3:    op = OP_SLEEP;
          4'h4:    op = OP_WDTC;
          4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hF: op = OP_IOW;
          4'hA:    op = OP_ENI;
          4'hB:    op = OP_DISI;
          4'hC:    op = OP_RET;
          4'hD:    op = OP_RETI;
          4'hE:    op = OP_CONTR;
          default: op = OP_NONE;
        endcase
      end else if (w[3:0] >= 4'h5) begin
        op = OP_IOR;
      end
    end
    return op;
  endfunction

  // Decimal adjust: returns {carry_out, result}.
  function automatic logic [DATA_W:0] daa_calc(input logic [DATA_W-1:0] a,
                                               input logic c,
                                               input logic dc);
    logic [DATA_W:0] step;
    logic            hi_fix;
    step = {1'b0, a};
    if ((a[3:0] > 4'd9) || dc)
      step = step + 9'h006;
    hi_fix = step[DATA_W] || (step[7:4] > 4'd9) || c;
    if (hi_fix)
      step = step + 9'h060;
    return {hi_fix, step[DATA_W-1:0]};
  endfunction

endpackage

// File: rtl/sys_seq_decode.sv
module sys_seq_decode
  import sys_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               asleep,
  output logic               dec_daa,
  output logic               dec_contw,
  output logic               dec_sleep,
  output logic               dec_wdtc,
  output logic               dec_iow,
  output logic               dec_eni,
  output logic               dec_disi,
  output logic               dec_ret,
  output logic               dec_reti,
  output logic               dec_contr,
  output logic               dec_ior,
  output logic [IOC_W-1:0]   ioc_idx
);

  sys_op_e op;
  logic    accept;

  assign accept  = instr_valid && !asleep;
  assign op      = sys_classify(instr);
  assign ioc_idx = instr[IOC_W-1:0];

  assign dec_daa   = accept && (op == OP_DAA);
  assign dec_contw = accept && (op == OP_CONTW);
  assign dec_sleep = accept && (op == OP_SLEEP);
  assign dec_wdtc  = accept && (op == OP_WDTC);
  assign dec_iow   = accept && (op == OP_IOW);
  assign dec_eni   = accept && (op == OP_ENI);
  assign dec_disi  = accept && (op == OP_DISI);
  assign dec_ret   = accept && (op == OP_RET);
  assign dec_reti  = accept && (op == OP_RETI);
  assign dec_contr = accept && (op == OP_CONTR);
  assign dec_ior   = accept && (op == OP_IOR);

  // R2
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_daa, dec_contw, dec_sleep, dec_wdtc, dec_iow, dec_eni,
              dec_disi, dec_ret, dec_reti, dec_contr, dec_ior}));

  // R11
  asleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !(dec_daa || dec_contw || dec_sleep || dec_wdtc || dec_iow ||
                 dec_eni || dec_disi || dec_ret || dec_reti || dec_contr || dec_ior));

endmodule

// File: rtl/sys_seq_stack.sv
module sys_seq_stack #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic [PC_W-1:0] push_addr,
  input  logic            pop_en,
  output logic [PC_W-1:0] pop_data
);

  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PC_W-1:0] slot_q [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] top_idx;

  assign top_idx  = sp_q - 1'b1;
  assign pop_data = slot_q[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      if (push_en && pop_en) begin
        slot_q[top_idx] <= push_addr;
      end else if (push_en) begin
        slot_q[sp_q] <= push_addr;
        sp_q         <= sp_q + 1'b1;
      end else if (pop_en) begin
        sp_q <= top_idx;
      end
    end
  end

  // R10
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !push_en) |=> (sp_q == SP_W'($past(sp_q) - 1'b1)));

  // R13
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && push_en) |=> $stable(sp_q));

endmodule

// File: rtl/sys_seq_status.sv
module sys_seq_status
  import sys_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_contw,
  input  logic              dec_sleep,
  input  logic              dec_wdtc,
  input  logic              dec_eni,
  input  logic              dec_disi,
  input  logic              dec_reti,
  input  logic              wake,
  input  logic [DATA_W-1:0] acc_rdata,
  output logic [DATA_W-1:0] cont_q,
  output logic              gie_q,
  output logic              asleep_q,
  output logic              t_q,
  output logic              p_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q   <= '0;
      gie_q    <= 1'b0;
      asleep_q <= 1'b0;
      t_q      <= 1'b1;
      p_q      <= 1'b1;
    end else begin
      if (dec_contw) cont_q <= acc_rdata;
      if (dec_eni || dec_reti) gie_q <= 1'b1;
      else if (dec_disi)       gie_q <= 1'b0;
      if (dec_sleep) begin
        asleep_q <= 1'b1;
        t_q      <= 1'b1;
        p_q      <= 1'b0;
      end else if (dec_wdtc) begin
        t_q <= 1'b1;
        p_q <= 1'b1;
      end else if (asleep_q && wake) begin
        asleep_q <= 1'b0;
      end
    end
  end

  // R7
  eni_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_eni |=> gie_q);

  // R7
  disi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_disi |=> !gie_q);

  // R9
  reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_reti |=> gie_q);

  // R11
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_sleep |=> (asleep_q && t_q && !p_q));

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && !wake) |=> asleep_q);

  // R12
  wdtc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_wdtc |=> (t_q && p_q && !asleep_q));

endmodule

// File: rtl/sys_seq.sv
module sys_seq
  import sys_seq_pkg::*;
#(
  parameter int PC_W        = 10,
  parameter int STACK_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  acc_rdata,
  input  logic               c_in,
  input  logic               dc_in,
  input  logic [DATA_W-1:0]  ioc_rdata,
  input  logic               push_en,
  input  logic [PC_W-1:0]    push_addr,
  input  logic               wake,
  output logic               acc_we,
  output logic [DATA_W-1:0]  acc_wdata,
  output logic               c_we,
  output logic               c_wdata,
  output logic               ioc_we,
  output logic               ioc_re,
  output logic [IOC_W-1:0]   ioc_addr,
  output logic [DATA_W-1:0]  ioc_wdata,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_target,
  output logic [DATA_W-1:0]  cont_value,
  output logic               gie,
  output logic               wdt_clr,
  output logic               osc_stop,
  output logic               t_flag,
  output logic               p_flag
);

  logic dec_daa, dec_contw, dec_sleep, dec_wdtc, dec_iow, dec_eni;
  logic dec_disi, dec_ret, dec_reti, dec_contr, dec_ior;
  logic ret_any;
  logic asleep;
  logic [IOC_W-1:0]  ioc_idx;
  logic [PC_W-1:0]   stack_top;
  logic [DATA_W:0]   daa_out;
  logic [DATA_W-1:0] cont_q;

  sys_seq_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .instr      (instr),
    .asleep     (asleep),
    .dec_daa    (dec_daa),
    .dec_contw  (dec_contw),
    .dec_sleep  (dec_sleep),
    .dec_wdtc   (dec_wdtc),
    .dec_iow    (dec_iow),
    .dec_eni    (dec_eni),
    .dec_disi   (dec_disi),
    .dec_ret    (dec_ret),
    .dec_reti   (dec_reti),
    .dec_contr  (dec_contr),
    .dec_ior    (dec_ior),
    .ioc_idx    (ioc_idx)
  );

  assign ret_any = dec_ret || dec_reti;

  sys_seq_stack #(.PC_W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (push_en),
    .push_addr(push_addr),
    .pop_en   (ret_any),
    .pop_data (stack_top)
  );

  sys_seq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_contw(dec_contw),
    .dec_sleep(dec_sleep),
    .dec_wdtc (dec_wdtc),
    .dec_eni  (dec_eni),
    .dec_disi (dec_disi),
    .dec_reti (dec_reti),
    .wake     (wake),
    .acc_rdata(acc_rdata),
    .cont_q   (cont_q),
    .gie_q    (gie),
    .asleep_q (asleep),
    .t_q      (t_flag),
    .p_q      (p_flag)
  );

  assign daa_out    = daa_calc(acc_rdata, c_in, dc_in);
  assign cont_value = cont_q;
  assign osc_stop   = asleep;

  assign ioc_we    = dec_iow;
  assign ioc_re    = dec_ior;
  assign ioc_addr  = ioc_idx;
  assign ioc_wdata = acc_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_we    <= 1'b0;
      acc_wdata <= '0;
      c_we      <= 1'b0;
      c_wdata   <= 1'b0;
      pc_load   <= 1'b0;
      pc_target <= '0;
      wdt_clr   <= 1'b0;
    end else begin
      acc_we  <= dec_daa || dec_contr || dec_ior;
      c_we    <= dec_daa;
      pc_load <= ret_any;
      wdt_clr <= dec_sleep || dec_wdtc;
      if (dec_daa)        acc_wdata <= daa_out[DATA_W-1:0];
      else if (dec_contr) acc_wdata <= cont_q;
      else if (dec_ior)   acc_wdata <= ioc_rdata;
      if (dec_daa) c_wdata   <= daa_out[DATA_W];
      if (ret_any) pc_target <= stack_top;
    end
  end

  // R5
  ioc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_we |-> (ioc_addr >= 4'h5 && ioc_addr != 4'hA && ioc_addr != 4'hB &&
                ioc_addr != 4'hC && ioc_addr != 4'hD && ioc_addr != 4'hE));

  // R6
  ioc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ioc_we, ioc_re}));

  // R8
  ret_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_any |=> pc_load);

  // R8
  no_stray_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_any |=> !pc_load);

  // R4
  carry_only_daa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_contr || dec_ior) |=> !c_we);

endmodule

// File: tb/sys_seq_bench.sv
module sys_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            instr_valid;
  logic [12:0]     instr;
  logic [7:0]      acc_rdata;
  logic            c_in, dc_in;
  logic [7:0]      ioc_rdata;
  logic            push_en;
  logic [PC_W-1:0] push_addr;
  logic            wake;
  logic            acc_we, c_we, c_wdata, ioc_we, ioc_re, pc_load;
  logic [7:0]      acc_wdata, ioc_wdata, cont_value;
  logic [3:0]      ioc_addr;
  logic [PC_W-1:0] pc_target;
  logic            gie, wdt_clr, osc_stop, t_flag, p_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ioc_rdata = 8'hC0 ^ {4'h0, ioc_addr};

  sys_seq #(.PC_W(PC_W), .STACK_DEPTH(8)) u_sys_seq (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .acc_rdata(acc_rdata), .c_in(c_in), .dc_in(dc_in), .ioc_rdata(ioc_rdata),
    .push_en(push_en), .push_addr(push_addr), .wake(wake),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .c_we(c_we), .c_wdata(c_wdata),
    .ioc_we(ioc_we), .ioc_re(ioc_re), .ioc_addr(ioc_addr), .ioc_wdata(ioc_wdata),
    .pc_load(pc_load), .pc_target(pc_target), .cont_value(cont_value),
    .gie(gie), .wdt_clr(wdt_clr), .osc_stop(osc_stop),
    .t_flag(t_flag), .p_flag(p_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Offer a word at the falling edge; return at the next falling edge.
  task automatic issue(input logic [12:0] w);
    instr = w;
    instr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; acc_rdata = '0;
    c_in = 1'b0; dc_in = 1'b0; push_en = 1'b0; push_addr = '0; wake = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [PC_W-1:0] a);
    push_en = 1'b1; push_addr = a;
    @(posedge clk);
    @(negedge clk);
    push_en = 1'b0;
  endtask

  task automatic t_reset_state;
    chk(gie == 1'b0, "R1 gie", gie, 0);
    chk(t_flag && p_flag, "R1 T/P", {t_flag, p_flag}, 3);
    chk(cont_value == 8'h00 && !osc_stop, "R1 cont/sleep", cont_value, 0);
    chk(!(acc_we || c_we || pc_load || wdt_clr || ioc_we || ioc_re), "R1 strobes",
        {acc_we, c_we, pc_load, wdt_clr, ioc_we, ioc_re}, 0);
  endtask

  task automatic t_daa;
    int av [6] = '{8'h15, 8'h0A, 8'h9A, 8'h12, 8'h45, 8'hFF};
    int cv [6] = '{0, 0, 0, 0, 1, 0};
    int dv [6] = '{0, 0, 0, 1, 0, 0};
    for (int i = 0; i < 6; i++) begin
      int v;
      int cy;
      v = av[i];
      if ((v % 16) > 9 || dv[i] != 0) v = v + 6;
      if ((v / 16) > 9 || cv[i] != 0) begin v = v + 96; cy = 1; end
      else cy = 0;
      acc_rdata = av[i][7:0]; c_in = cv[i][0]; dc_in = dv[i][0];
      issue(13'h0001);
      chk(acc_we && c_we, "R3 strobes", {acc_we, c_we}, 3);
      chk(acc_wdata == v[7:0], "R3 result", acc_wdata, v % 256);
      chk(c_wdata == cy[0], "R3 carry", c_wdata, cy);
    end
    c_in = 1'b0; dc_in = 1'b0;
  endtask

  task automatic t_cont;
    acc_rdata = 8'h5C;
    issue(13'h0002);
    chk(cont_value == 8'h5C, "R4 write", cont_value, 8'h5C);
    chk(!acc_we && !c_we, "R4 no flag write", {acc_we, c_we}, 0);
    acc_rdata = 8'h11;
    issue(13'h000E);
    chk(acc_we && acc_wdata == 8'h5C && !c_we, "R4 read", acc_wdata, 8'h5C);
  endtask

  task automatic t_iow;
    int idx [6] = '{5, 6, 7, 8, 9, 15};
    for (int i = 0; i < 6; i++) begin
      instr = {9'h000, idx[i][3:0]};
      acc_rdata = 8'h30 + idx[i][7:0];
      instr_valid = 1'b1;
      #1;
      chk(ioc_we && !ioc_re && ioc_addr == idx[i][3:0] && ioc_wdata == acc_rdata,
          "R5 write strobe", {ioc_we, ioc_addr}, {1'b1, idx[i][3:0]});
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
    end
  endtask

  task automatic t_ior;
    for (int r = 5; r < 16; r++) begin
      logic [7:0] exp_v;
      exp_v = 8'hC0 ^ r[7:0];
      instr = {9'h001, r[3:0]};
      instr_valid = 1'b1;
      #1;
      chk(ioc_re && !ioc_we && ioc_addr == r[3:0], "R6 read strobe", {ioc_re, ioc_addr}, {1'b1, r[3:0]});
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
      chk(acc_we && acc_wdata == exp_v, "R6 read data", acc_wdata, exp_v);
    end
  endtask

  task automatic t_ignored;
    logic [12:0] words [6] = '{13'h0000, 13'h0010, 13'h0014, 13'h0020, 13'h0C0F, 13'h1FFF};
    logic g0;
    logic [7:0] c0;
    g0 = gie; c0 = cont_value;
    for (int i = 0; i < 6; i++) begin
      instr = words[i];
      acc_rdata = 8'hA5;
      instr_valid = 1'b1;
      #1;
      chk(!ioc_we && !ioc_re, "R2/R6 no io strobe", {ioc_we, ioc_re}, 0);
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
      chk(!(acc_we || c_we || pc_load || wdt_clr), "R2 no strobe",
          {acc_we, c_we, pc_load, wdt_clr}, 0);
      chk(gie == g0 && cont_value == c0 && !osc_stop, "R2 state kept", cont_value, c0);
    end
  endtask

  task automatic t_gie;
    issue(13'h000A);
    chk(gie == 1'b1, "R7 enable", gie, 1);
    issue(13'h000B);
    chk(gie == 1'b0, "R7 disable", gie, 0);
  endtask

  task automatic t_ret;
    push(10'h123);
    push(10'h2AB);
    issue(13'h000C);
    chk(pc_load && pc_target == 10'h2AB, "R8 first return", pc_target, 10'h2AB);
    chk(gie == 1'b0, "R8 gie kept", gie, 0);
    issue(13'h000D);
    chk(pc_load && pc_target == 10'h123, "R9 return target", pc_target, 10'h123);
    chk(gie == 1'b1, "R9 gie set", gie, 1);
    issue(13'h000B);
  endtask

  task automatic t_wrap;
    for (int i = 1; i <= 9; i++) push(PC_W'(10'h100 + i));
    for (int i = 9; i >= 2; i--) begin
      issue(13'h000C);
      chk(pc_load && pc_target == PC_W'(10'h100 + i), "R10 lifo", pc_target, 10'h100 + i);
    end
    issue(13'h000C);
    chk(pc_target == 10'h109, "R10 wrap", pc_target, 10'h109);
  endtask

  task automatic t_swap;
    push(10'h0AA);
    push_en = 1'b1; push_addr = 10'h0BB;
    issue(13'h000C);
    push_en = 1'b0;
    chk(pc_target == 10'h0AA, "R13 old top", pc_target, 10'h0AA);
    issue(13'h000C);
    chk(pc_target == 10'h0BB, "R13 new top", pc_target, 10'h0BB);
  endtask

  task automatic t_sleep;
    issue(13'h0003);
    chk(wdt_clr == 1'b1, "R11 wdt pulse", wdt_clr, 1);
    chk(osc_stop && t_flag && !p_flag, "R11 sleep flags", {osc_stop, t_flag, p_flag}, 3'b110);
    @(negedge clk);
    chk(wdt_clr == 1'b0, "R11 pulse ends", wdt_clr, 0);
    instr = 13'h000A;
    instr_valid = 1'b1;
    #1;
    chk(!ioc_we && !ioc_re, "R11 asleep no io", {ioc_we, ioc_re}, 0);
    instr = 13'h0007;
    #1;
    chk(!ioc_we, "R11 asleep no write", ioc_we, 0);
    instr = 13'h000A;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(gie == 1'b0 && osc_stop, "R11 ignored while asleep", gie, 0);
    wake = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wake = 1'b0;
    chk(!osc_stop, "R11 wake", osc_stop, 0);
  endtask

  task automatic t_wdtc;
    issue(13'h0004);
    chk(wdt_clr && t_flag && p_flag && !osc_stop, "R12 wdt clear",
        {wdt_clr, t_flag, p_flag, osc_stop}, 4'b1110);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_daa();
    t_cont();
    t_iow();
    t_ior();
    t_ignored();
    t_gie();
    t_ret();
    do_reset();
    t_wrap();
    t_swap();
    t_sleep();
    t_wdtc();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule